// File: doc/BRIEF.md
# Chained Serial Configuration Receiver

This block sits at the configuration input of one device in a serial chain of devices. Every device shares one configuration clock. Each device samples its serial data input on that clock and sends a registered copy of the stream on to the next device. The line idles at one. The receiver waits for a four-bit header mark. It then captures the 24-bit total length that the whole chain shares and passes the complete header downstream unchanged.

Once the header has passed, the receiver absorbs its own configuration frames and holds its serial output at one while it does so. Each frame is handed to a local sink through a one-cycle valid pulse. When the device has all the frames it needs, it forwards every later bit, so that devices further down the chain get their data. The receiver counts the clocks that arrive after reset. All devices see the same clock and the same length, so all of them signal start-up on the same edge. The I/O release follows two clocks after start-up.

An active-low program input clears the block at any time. After the program input rises, the block waits two clock edges as its reset release is synchronized. The next edge samples stream bit 1.

Top module: `cfg_chain_rx`

## Requirements
- R1: The header mark is the 4-bit sequence 0,0,1,0 in time order. The search runs over a sliding window of the last four sampled bits, and that window starts at all ones. Any bits that do not complete the mark, including ones and partial marks, are passed over.
- R2: The 24 bits that follow the mark are captured as the length count, most significant bit first.
- R3: Every bit sampled up to and including the last length bit appears on `cfg_dout` one clock later. The output is a register loaded on the rising clock edge.
- R4: From the first bit after the length count through the last data bit of the device's final own frame, `cfg_dout` is 1 one clock after each sample.
- R5: A frame is a single 0 start bit followed by FRAME_BITS data bits, most significant bit first. Ones between frames are skipped. After the edge that samples a frame's last data bit, `frame_valid` is high for exactly one cycle and `frame_data` holds that frame.
- R6: After FRAMES_NEEDED frames have been taken, `cfg_dout` again copies every sampled bit one clock later, and `frame_valid` stays low.
- R7: Counted edges start with the first edge that samples stream bit 1. `startup_done` rises after counted edge N, where N is the captured length, and it stays high. N must be larger than the index of the last length bit.
- R8: `io_release` rises two clock edges after `startup_done` and stays high.
- R9: While `prog_n` is low, all of the following hold at once: `cfg_dout` is 1, `frame_valid`, `startup_done` and `io_release` are 0, and the header search restarts. The two clock edges after `prog_n` rises are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Shared configuration clock; data sampled on its rising edge |
| prog_n | input | 1 | Active-low program/reset, asynchronous assert |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Registered serial data out to the next device |
| frame_valid | output | 1 | One-cycle pulse when an own frame is complete |
| frame_data | output | FRAME_BITS | Data bits of the frame just completed |
| startup_done | output | 1 | Start-up begins; clock count reached the length count |
| io_release | output | 1 | I/O may be released, two clocks after start-up |

## Verification
The streams put decoy patterns in front of the header mark: partial marks and runs that hold two of the mark's zeros. A detector that is stuck on a partial match, or that does not slide its window, would lock onto the wrong bit and shift every later expectation. Each run checks the output cycle by cycle across the boundary between the header and the own frames and across the boundary between the last own frame and forwarding. An off-by-one in the gating would leak a data bit or hide a forwarded start bit. The frames cover all-ones and all-zeros payloads, zero-length and two-bit gaps, and back-to-back frames. One run sets the length to one bit past the header, which catches a start-up compare that is late or that waits for the frames. Start-up and release are checked on the exact edge and on the edge before it, and reset is applied after both outputs are high.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  typedef enum logic [1:0] {
    PH_SEARCH = 2'd0,
    PH_LENGTH = 2'd1,
    PH_OWN    = 2'd2,
    PH_FWD    = 2'd3
  } cfg_phase_e;
endpackage

// File: rtl/cfg_hdr_det.sv
module cfg_hdr_det #(
  parameter int          LEN_W    = 24,
  parameter int          PRE_W    = 4,
  parameter logic [3:0]  PRE_PAT  = 4'b0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             search_en,
  input  logic             len_en,
  output logic             pre_hit,
  output logic             len_last,
  output logic             len_valid,
  output logic [LEN_W-1:0] len_q
);
  localparam int LC_W = $clog2(LEN_W);

  logic [PRE_W-1:0] win_q, win_d;
  logic [LEN_W-1:0] len_sr_q, len_sr_d;
  logic [LC_W-1:0]  lcnt_q, lcnt_d;
  logic             lval_q, lval_d;
  logic [PRE_W-1:0] win_next;

  assign win_next = {win_q[PRE_W-2:0], din};
  assign pre_hit  = search_en && (win_next == PRE_PAT[PRE_W-1:0]);
  assign len_last = len_en && (lcnt_q == LC_W'(LEN_W-1));

  always_comb begin
    win_d    = win_q;
    len_sr_d = len_sr_q;
    lcnt_d   = lcnt_q;
    lval_d   = lval_q;
    if (search_en) win_d = win_next;
    if (len_en) begin
      len_sr_d = {len_sr_q[LEN_W-2:0], din};
      lcnt_d   = lcnt_q + 1'b1;
      if (len_last) lval_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= '1;
      len_sr_q <= '0;
      lcnt_q   <= '0;
      lval_q   <= 1'b0;
    end else begin
      win_q    <= win_d;
      len_sr_q <= len_sr_d;
      lcnt_q   <= lcnt_d;
      lval_q   <= lval_d;
    end
  end

  assign len_valid = lval_q;
  assign len_q     = len_sr_q;

  assert_len_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lval_q |=> $stable(len_sr_q));
endmodule

// File: rtl/cfg_frame_col.sv
module cfg_frame_col #(
  parameter int FRAME_BITS    = 8,
  parameter int FRAMES_NEEDED = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  din,
  input  logic                  en,
  output logic                  last_done,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_data
);
  localparam int BC_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int FC_W = $clog2(FRAMES_NEEDED + 1);

  logic                  busy_q, busy_d;
  logic [BC_W-1:0]       bcnt_q, bcnt_d;
  logic [FC_W-1:0]       fcnt_q, fcnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  vld_q, vld_d;
  logic                  bit_last;

  assign bit_last  = busy_q && (bcnt_q == BC_W'(FRAME_BITS-1));
  assign last_done = en && bit_last && (fcnt_q == FC_W'(FRAMES_NEEDED-1));

  always_comb begin
    busy_d = busy_q;
    bcnt_d = bcnt_q;
    fcnt_d = fcnt_q;
    sh_d   = sh_q;
    vld_d  = 1'b0;
    if (en) begin
      if (!busy_q) begin
        if (!din) begin
          busy_d = 1'b1;
          bcnt_d = '0;
        end
      end else begin
        sh_d = {sh_q[FRAME_BITS-2:0], din};
        if (bit_last) begin
          busy_d = 1'b0;
          vld_d  = 1'b1;
          fcnt_d = fcnt_q + 1'b1;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bcnt_q <= '0;
      fcnt_q <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      bcnt_q <= bcnt_d;
      fcnt_q <= fcnt_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
    end
  end

  assign frame_valid = vld_q;
  assign frame_data  = sh_q;

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  assert_frame_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= FC_W'(FRAMES_NEEDED));
endmodule

// File: rtl/cfg_startup_tmr.sv
module cfg_startup_tmr #(
  parameter int LEN_W   = 24,
  parameter int REL_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_valid,
  input  logic [LEN_W-1:0] len_q,
  output logic             done,
  output logic             io_rel
);
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic               done_q, done_d;
  logic [REL_DLY-1:0] rel_q, rel_d;

  always_comb begin
    cnt_d  = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
    done_d = done_q | (len_valid && (cnt_d == len_q));
    rel_d  = {rel_q[REL_DLY-2:0], done_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      rel_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      rel_q  <= rel_d;
    end
  end

  assign done   = done_q;
  assign io_rel = rel_q[REL_DLY-1];

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  assert_done_needs_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> len_valid);
  assert_rel_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    io_rel |-> done_q);
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx
  import cfg_chain_pkg::*;
#(
  parameter int FRAME_BITS    = 8,
  parameter int FRAMES_NEEDED = 4,
  parameter int LEN_W         = 24
) (
  input  logic                  cfg_clk,
  input  logic                  prog_n,
  input  logic                  cfg_din,
  output logic                  cfg_dout,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic                  startup_done,
  output logic                  io_release
);
  logic [1:0]  rsync_q;
  logic        rst_n;
  cfg_phase_e  ph_q, ph_d;
  logic        dout_q, dout_d;
  logic        pre_hit, len_last, len_valid, last_done;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge cfg_clk or negedge prog_n) begin
    if (!prog_n) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  cfg_hdr_det #(.LEN_W(LEN_W), .PRE_W(4), .PRE_PAT(4'b0010)) hdr_i (
    .clk(cfg_clk), .rst_n(rst_n), .din(cfg_din),
    .search_en(ph_q == PH_SEARCH), .len_en(ph_q == PH_LENGTH),
    .pre_hit(pre_hit), .len_last(len_last),
    .len_valid(len_valid), .len_q(len_q)
  );

  cfg_frame_col #(.FRAME_BITS(FRAME_BITS), .FRAMES_NEEDED(FRAMES_NEEDED)) col_i (
    .clk(cfg_clk), .rst_n(rst_n), .din(cfg_din), .en(ph_q == PH_OWN),
    .last_done(last_done), .frame_valid(frame_valid), .frame_data(frame_data)
  );

  cfg_startup_tmr #(.LEN_W(LEN_W), .REL_DLY(2)) tmr_i (
    .clk(cfg_clk), .rst_n(rst_n), .len_valid(len_valid), .len_q(len_q),
    .done(startup_done), .io_rel(io_release)
  );

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_SEARCH: if (pre_hit)   ph_d = PH_LENGTH;
      PH_LENGTH: if (len_last)  ph_d = PH_OWN;
      PH_OWN:    if (last_done) ph_d = PH_FWD;
      default:   ph_d = PH_FWD;
    endcase
    dout_d = (ph_q == PH_OWN) ? 1'b1 : cfg_din;
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_SEARCH;
      dout_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      dout_q <= dout_d;
    end
  end

  assign cfg_dout = dout_q;

  assert_len_after_mark_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (ph_q == PH_LENGTH) |-> ($past(ph_q) == PH_SEARCH || $past(ph_q) == PH_LENGTH));
  assert_no_frame_in_header_R5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (ph_q == PH_SEARCH || ph_q == PH_LENGTH) |-> !frame_valid);
endmodule

// File: tb/cfg_chain_rx_tb_top.sv
module cfg_chain_rx_tb_top;
  localparam int CLK_P = 10;
  localparam int FB    = 5;
  localparam int NF    = 2;
  localparam int MAXB  = 600;

  logic cfg_clk, prog_n, cfg_din;
  logic cfg_dout, frame_valid, startup_done, io_release;
  logic [FB-1:0] frame_data;

  int n_chk, n_fail;
  bit finished;

  logic stream [1:MAXB];
  int   slen, len_end, own_end, n_len;
  int   fend [0:7];
  logic [FB-1:0] fdat [0:7];
  int   nfr;

  cfg_chain_rx #(.FRAME_BITS(FB), .FRAMES_NEEDED(NF), .LEN_W(24)) dut_i (
    .cfg_clk(cfg_clk), .prog_n(prog_n), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .frame_valid(frame_valid), .frame_data(frame_data),
    .startup_done(startup_done), .io_release(io_release)
  );

  initial cfg_clk = 1'b0;
  always #(CLK_P/2) cfg_clk = ~cfg_clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic b);
    slen++;
    stream[slen] = b;
  endtask

  task automatic push_ones(input int n);
    for (int k = 0; k < n; k++) push(1'b1);
  endtask

  task automatic push_mark();
    push(1'b0); push(1'b0); push(1'b1); push(1'b0);
  endtask

  task automatic push_len_slot();
    for (int k = 0; k < 24; k++) push(1'b0);
    len_end = slen;
  endtask

  task automatic push_frame(input logic [FB-1:0] d, input bit own);
    push(1'b0);
    for (int k = FB-1; k >= 0; k--) push(d[k]);
    if (own) begin
      fend[nfr] = slen;
      fdat[nfr] = d;
      nfr++;
      own_end = slen;
    end
  endtask

  task automatic set_len(input int n);
    n_len = n;
    for (int k = 0; k < 24; k++) stream[len_end - k] = n[k];
  endtask

  task automatic new_stream();
    slen = 0; nfr = 0; own_end = 0; len_end = 0;
  endtask

  task automatic do_reset();
    @(negedge cfg_clk);
    prog_n = 1'b0;
    cfg_din = 1'b1;
    #1;
    // R9: asynchronous clear, checked away from the edge
    chk(cfg_dout === 1'b1, "R9", "dout in reset", int'(cfg_dout), 1);
    chk(frame_valid === 1'b0, "R9", "frame_valid in reset", int'(frame_valid), 0);
    chk(startup_done === 1'b0, "R9", "done in reset", int'(startup_done), 0);
    chk(io_release === 1'b0, "R9", "io_release in reset", int'(io_release), 0);
    @(negedge cfg_clk);
    prog_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge cfg_clk); #1;
      chk(cfg_dout === 1'b1 && startup_done === 1'b0, "R9", "sync release idle",
          int'(cfg_dout), 1);
    end
  endtask

  task automatic play();
    int fi;
    bit in_own, exp_fv;
    logic exp_do;
    fi = 0;
    for (int i = 1; i <= slen; i++) begin
      @(negedge cfg_clk);
      cfg_din = stream[i];
      @(posedge cfg_clk); #1;
      in_own = (i > len_end) && ((nfr == 0) || (i <= own_end));
      exp_do = in_own ? 1'b1 : stream[i];
      if (i <= len_end)
        chk(cfg_dout === exp_do, "R3", $sformatf("header dout bit %0d", i), int'(cfg_dout), int'(exp_do));
      else if (in_own)
        chk(cfg_dout === exp_do, "R4", $sformatf("own dout bit %0d", i), int'(cfg_dout), int'(exp_do));
      else
        chk(cfg_dout === exp_do, "R6", $sformatf("fwd dout bit %0d", i), int'(cfg_dout), int'(exp_do));
      exp_fv = (fi < nfr) && (fend[fi] == i);
      chk(frame_valid === exp_fv, exp_fv ? "R5" : "R6",
          $sformatf("frame_valid bit %0d", i), int'(frame_valid), int'(exp_fv));
      if (exp_fv) begin
        chk(frame_data === fdat[fi], "R5", $sformatf("frame_data %0d", fi),
            int'(frame_data), int'(fdat[fi]));
        fi++;
      end
      chk(startup_done === (i >= n_len), "R7", $sformatf("done bit %0d", i),
          int'(startup_done), int'(i >= n_len));
      chk(io_release === (i >= n_len + 2), "R8", $sformatf("io_release bit %0d", i),
          int'(io_release), int'(i >= n_len + 2));
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    prog_n = 1'b0; cfg_din = 1'b1;

    // Run A: idle, decoy, R1 mark, R2 length, gaps between own frames, forwarding
    do_reset();
    new_stream();
    push_ones(5);
    push(1'b0); push(1'b1); push(1'b1); push(1'b0);
    push_mark();
    push_len_slot();
    push_frame(5'b10110, 1'b1);
    push_ones(2);
    push_frame(5'b01001, 1'b1);
    push_frame(5'b11100, 1'b0);
    push_ones(1);
    push_frame(5'b00011, 1'b0);
    push_ones(3);
    set_len(slen + 3);
    push_ones(n_len - slen + 4);
    play();

    // Run B: reset with done high, then R1 decoy 0011, back-to-back extreme frames
    do_reset();
    new_stream();
    push(1'b0); push(1'b0); push(1'b1); push(1'b1);
    push_mark();
    push_len_slot();
    push_frame(5'b11111, 1'b1);
    push_frame(5'b00000, 1'b1);
    push_frame(5'b10101, 1'b0);
    for (int k = 0; k < 6; k++) push(1'b0);
    set_len(slen + 10);
    push_ones(n_len - slen + 4);
    play();

    // Run C: R7 boundary, length one past the header, no frames
    do_reset();
    new_stream();
    push_ones(2);
    push_mark();
    push_len_slot();
    set_len(len_end + 1);
    push_ones(6);
    play();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule